// File: doc/BRIEF.md
# USB host command-status register unit

This unit holds the command/status word of a USB host controller and the interrupt-status logic next to it. Software reaches it over a simple 32-bit register bus with word addresses. Two list-filled flags, one for the control list and one for the bulk list, tell the list-processing engine whether a pass over that list is worth making. Software raises a flag each time it queues a transfer descriptor. The hardware drops the flag when a pass begins and raises it again when the pass meets a descriptor. A pass that meets nothing therefore ends with the flag low, and the list goes idle.

A self-clearing soft-reset request puts the controller into a suspend state for a fixed number of cycles. That number is a parameter standing for the 10 µs completion limit. On entry the request wipes the operational state but keeps the interrupt-routing field. While suspended, the engine handshakes are ignored. Event bits are sticky and are cleared only when software writes 1 to them. The interrupt output is masked by a per-event enable and a master enable.

Addresses: 0 is the command word (bit 0 reset request/busy, bit 1 control-list filled, bit 2 bulk-list filled). 1 is the event status (bits EVT_W-1:0). 2 is the enable word (bits EVT_W-1:0 per-event enables, bit 30 routing field, bit 31 master enable). Reads of address 3 return 0. Index 0 of every two-bit list port is the control list and index 1 is the bulk list.

Top module: `usb_cmdstat_unit`

## Requirements
- R1: A write to address 0 with bit 1 or bit 2 at 1 sets the control or bulk filled flag in the next cycle. A bit written as 0 leaves its flag unchanged. Address 0 reads back bit 0 = reset busy, bit 1 = control filled, bit 2 = bulk filled, and all other bits 0.
- R2: When a list-start pulse comes while that list's flag is 0, the pass is skipped and pass_o stays 0. When it comes while the flag is 1, the next cycle shows the flag at 0 and pass_o at 1.
- R3: A descriptor-found pulse during an active pass sets that list's flag. A found pulse while no pass is active is ignored. A list-done pulse ends the pass (pass_o goes to 0) and leaves the flag as it is.
- R4: If a software set and a list start for the same list fall in the same cycle, the software set wins: the flag stays 1 and the pass starts.
- R5: Writing 1 to address 0 bit 0 raises bit 0 and suspend_o in the next cycle. They stay high for exactly RST_CYCLES cycles and then clear by themselves. Writing bit 0 again while busy has no effect on the duration.
- R6: When a reset request is accepted, it clears both flags, both passes, the event status, the per-event enables and the master enable. It keeps the routing field (address 2 bit 30, route_o). While suspend_o is high, list handshake inputs have no effect, but software can still set the flags.
- R7: An event pulse sets its status bit at address 1. Writing 1 to a status bit clears it, and writing 1 to a bit that is 0 does not set it. An event in the same cycle as a clear of that bit leaves the bit set.
- R8: irq_o is 1 exactly when the master enable is 1 and some status bit has its enable bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| list_start_i | input | 2 | Pass begins at list head (0 control, 1 bulk) |
| td_found_i | input | 2 | Descriptor found during pass |
| list_done_i | input | 2 | Pass finished |
| event_i | input | EVT_W | Event pulses into status |
| filled_o | output | 2 | List-filled flags |
| pass_o | output | 2 | List pass active |
| suspend_o | output | 1 | Soft reset in progress, controller held in suspend |
| route_o | output | 1 | Interrupt-routing field |
| irq_o | output | 1 | Masked interrupt |

## Verification
The flag handshake is driven by a sequence of start, found and done pulses, with and without software sets. This separates a skipped pass from a started pass, a pass that re-arms its flag from one that drains it, and a found pulse inside a pass from one outside it. Colliding software-set and start pulses, on one list and on both, show whether the set wins. The soft reset is sampled one cycle before and one cycle at its deadline to pin the exact duration. It is also hit with handshakes and repeat requests while busy, and the routing field is checked to survive the wipe. Event, clear and enable patterns separate the sticky status from the masked output, including an event that collides with a clear.

// File: rtl/usb_cmdstat_pkg.sv
package usb_cmdstat_pkg;
  localparam int unsigned NUM_LISTS = 2;
  localparam logic [1:0] ADDR_CMD = 2'd0;
  localparam logic [1:0] ADDR_STS = 2'd1;
  localparam logic [1:0] ADDR_ENA = 2'd2;
  localparam int unsigned BIT_SRST  = 0;
  localparam int unsigned BIT_LIST0 = 1;  // list i filled flag at BIT_LIST0+i
  localparam int unsigned BIT_ROUTE = 30;
  localparam int unsigned BIT_MIE   = 31;

  typedef struct packed {
    logic start;
    logic found;
    logic done;
  } list_hs_t;
endpackage

// File: rtl/usb_list_flag.sv
module usb_list_flag
  import usb_cmdstat_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     clr_i,
  input  logic     hold_i,
  input  logic     sw_set_i,
  input  list_hs_t hs_i,
  output logic     filled_o,
  output logic     pass_o
);
  logic filled_q, pass_q;
  logic start_ok, found_ok, done_ok;

  assign start_ok = hs_i.start & ~hold_i;
  assign found_ok = hs_i.found & ~hold_i & pass_q & ~hs_i.start;
  assign done_ok  = hs_i.done & ~hold_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filled_q <= 1'b0;
      pass_q   <= 1'b0;
    end else if (clr_i) begin
      filled_q <= 1'b0;
      pass_q   <= 1'b0;
    end else begin
      // software set beats the hardware clear at list start
      if (sw_set_i)      filled_q <= 1'b1;
      else if (start_ok) filled_q <= 1'b0;
      else if (found_ok) filled_q <= 1'b1;

      if (start_ok)     pass_q <= filled_q | sw_set_i;
      else if (done_ok) pass_q <= 1'b0;
    end
  end

  assign filled_o = filled_q;
  assign pass_o   = pass_q;
endmodule

// File: rtl/usb_srst_timer.sv
module usb_srst_timer #(
  parameter int unsigned RST_CYCLES = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic accept_o,
  output logic busy_o
);
  localparam int unsigned CNT_W = $clog2(RST_CYCLES > 1 ? RST_CYCLES : 2);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RST_CYCLES - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  assign accept_o = req_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/usb_irq_status.sv
module usb_irq_status #(
  parameter int unsigned EVT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [EVT_W-1:0] event_i,
  input  logic             wr_sts_i,
  input  logic             wr_ena_i,
  input  logic [EVT_W-1:0] wbits_i,
  input  logic             wmie_i,
  input  logic             wroute_i,
  output logic [EVT_W-1:0] status_o,
  output logic [EVT_W-1:0] ena_o,
  output logic             mie_o,
  output logic             route_o,
  output logic             irq_o
);
  logic [EVT_W-1:0] status_q, ena_q, clr_mask;
  logic             mie_q, route_q;

  assign clr_mask = wr_sts_i ? wbits_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      ena_q    <= '0;
      mie_q    <= 1'b0;
      route_q  <= 1'b0;
    end else if (clr_i) begin
      status_q <= '0;
      ena_q    <= '0;
      mie_q    <= 1'b0;
    end else begin
      // a new event outranks a clear of the same bit
      status_q <= (status_q & ~clr_mask) | event_i;
      if (wr_ena_i) begin
        ena_q   <= wbits_i;
        mie_q   <= wmie_i;
        route_q <= wroute_i;
      end
    end
  end

  assign status_o = status_q;
  assign ena_o    = ena_q;
  assign mie_o    = mie_q;
  assign route_o  = route_q;
  assign irq_o    = mie_q & |(status_q & ena_q);
endmodule

// File: rtl/usb_cmdstat_unit.sv
module usb_cmdstat_unit
  import usb_cmdstat_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 500,
  parameter int unsigned EVT_W      = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic [1:0]           reg_addr_i,
  input  logic [31:0]          reg_wdata_i,
  output logic [31:0]          reg_rdata_o,
  input  logic [NUM_LISTS-1:0] list_start_i,
  input  logic [NUM_LISTS-1:0] td_found_i,
  input  logic [NUM_LISTS-1:0] list_done_i,
  input  logic [EVT_W-1:0]     event_i,
  output logic [NUM_LISTS-1:0] filled_o,
  output logic [NUM_LISTS-1:0] pass_o,
  output logic                 suspend_o,
  output logic                 route_o,
  output logic                 irq_o
);
  logic             wr_cmd, wr_sts, wr_ena;
  logic             srst_accept, busy;
  logic [EVT_W-1:0] status, ena;
  logic             mie;
  logic             unused_wdata;

  assign wr_cmd = reg_we_i && (reg_addr_i == ADDR_CMD);
  assign wr_sts = reg_we_i && (reg_addr_i == ADDR_STS);
  assign wr_ena = reg_we_i && (reg_addr_i == ADDR_ENA);
  assign unused_wdata = ^reg_wdata_i[BIT_ROUTE-1:EVT_W];

  usb_srst_timer #(.RST_CYCLES(RST_CYCLES)) u_srst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (wr_cmd & reg_wdata_i[BIT_SRST]),
    .accept_o (srst_accept),
    .busy_o   (busy)
  );

  for (genvar i = 0; i < NUM_LISTS; i++) begin : g_list
    list_hs_t hs;
    assign hs = '{start: list_start_i[i], found: td_found_i[i], done: list_done_i[i]};
    usb_list_flag u_flag (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (srst_accept),
      .hold_i   (busy),
      .sw_set_i (wr_cmd & reg_wdata_i[BIT_LIST0+i]),
      .hs_i     (hs),
      .filled_o (filled_o[i]),
      .pass_o   (pass_o[i])
    );
  end

  usb_irq_status #(.EVT_W(EVT_W)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (srst_accept),
    .event_i  (event_i),
    .wr_sts_i (wr_sts),
    .wr_ena_i (wr_ena),
    .wbits_i  (reg_wdata_i[EVT_W-1:0]),
    .wmie_i   (reg_wdata_i[BIT_MIE]),
    .wroute_i (reg_wdata_i[BIT_ROUTE]),
    .status_o (status),
    .ena_o    (ena),
    .mie_o    (mie),
    .route_o  (route_o),
    .irq_o    (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_CMD: begin
        reg_rdata_o[BIT_SRST] = busy;
        reg_rdata_o[BIT_LIST0 +: NUM_LISTS] = filled_o;
      end
      ADDR_STS: reg_rdata_o[EVT_W-1:0] = status;
      ADDR_ENA: begin
        reg_rdata_o[EVT_W-1:0] = ena;
        reg_rdata_o[BIT_ROUTE] = route_o;
        reg_rdata_o[BIT_MIE]   = mie;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  assign suspend_o = busy;
endmodule

// File: rtl/usb_cmdstat_chk.sv
module usb_cmdstat_chk #(
  parameter int unsigned RST_CYCLES = 500
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_we_i,
  input logic [1:0] reg_addr_i,
  input logic [2:0] cmd_bits_i,
  input logic [1:0] list_start_i,
  input logic [1:0] td_found_i,
  input logic [1:0] filled_o,
  input logic [1:0] pass_o,
  input logic       suspend_o
);
  localparam int unsigned CW = $clog2(RST_CYCLES + 2);

  logic          sw_cmd;
  logic [CW-1:0] hi_cnt;

  assign sw_cmd = reg_we_i && (reg_addr_i == 2'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hi_cnt <= '0;
    else if (suspend_o) hi_cnt <= hi_cnt + 1'b1;
    else                hi_cnt <= '0;
  end

  for (genvar i = 0; i < 2; i++) begin : g_l
    a_r1_sw_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sw_cmd && cmd_bits_i[1+i] && !cmd_bits_i[0] |=> filled_o[i]);
    a_r2_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !suspend_o && list_start_i[i] && filled_o[i] && !sw_cmd |=> !filled_o[i] && pass_o[i]);
    a_r2_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !suspend_o && list_start_i[i] && !filled_o[i] && !sw_cmd |=> !pass_o[i]);
    a_r3_found_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !suspend_o && pass_o[i] && td_found_i[i] && !list_start_i[i] && !(sw_cmd && cmd_bits_i[0])
      |=> filled_o[i]);
    a_r4_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !suspend_o && list_start_i[i] && sw_cmd && cmd_bits_i[1+i] && !cmd_bits_i[0]
      |=> filled_o[i] && pass_o[i]);
  end

  a_r1_zero_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_cmd && cmd_bits_i == 3'b000 && list_start_i == 2'b00 && td_found_i == 2'b00
    |=> $stable(filled_o));
  a_r5_upper_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspend_o |-> hi_cnt < CW'(RST_CYCLES));
  a_r5_exact_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(suspend_o) |-> hi_cnt == CW'(RST_CYCLES));
  a_r6_no_pass_in_suspend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspend_o |-> pass_o == 2'b00);
endmodule

bind usb_cmdstat_unit usb_cmdstat_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_we_i     (reg_we_i),
  .reg_addr_i   (reg_addr_i),
  .cmd_bits_i   (reg_wdata_i[2:0]),
  .list_start_i (list_start_i),
  .td_found_i   (td_found_i),
  .filled_o     (filled_o),
  .pass_o       (pass_o),
  .suspend_o    (suspend_o)
);

// File: tb/usb_cmdstat_unit_bench.sv
module usb_cmdstat_unit_bench;
  localparam int unsigned RST = 20;
  localparam int unsigned EW  = 7;
  localparam int NV = 16;
  // {sw_set[1:0], start[1:0], found[1:0], done[1:0], exp_filled[1:0], exp_pass[1:0]}
  localparam logic [11:0] VEC [NV] = '{
    12'b00_01_00_00_00_00,
    12'b01_00_00_00_01_00,
    12'b00_01_00_00_00_01,
    12'b00_00_01_00_01_01,
    12'b00_00_00_01_01_00,
    12'b00_01_00_00_00_01,
    12'b00_00_00_01_00_00,
    12'b00_01_00_00_00_00,
    12'b10_10_00_00_10_10,
    12'b00_00_00_10_10_00,
    12'b11_11_00_00_11_11,
    12'b00_00_00_11_11_00,
    12'b00_11_00_00_00_11,
    12'b00_00_10_00_10_11,
    12'b00_00_00_11_10_00,
    12'b00_00_01_00_10_00
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          reg_we_i = 1'b0;
  logic [1:0]    reg_addr_i = '0;
  logic [31:0]   reg_wdata_i = '0;
  logic [31:0]   reg_rdata_o;
  logic [1:0]    list_start_i = '0, td_found_i = '0, list_done_i = '0;
  logic [EW-1:0] event_i = '0;
  logic [1:0]    filled_o, pass_o;
  logic          suspend_o, route_o, irq_o;

  int errors = 0;
  int checks = 0;
  logic [31:0] rv;

  always #10 clk_i = ~clk_i;

  usb_cmdstat_unit #(.RST_CYCLES(RST), .EVT_W(EW)) u_usb_cmdstat_unit (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic pulse_start(input logic [1:0] s);
    list_start_i = s;
    @(negedge clk_i);
    list_start_i = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // reset state
    rd(2'd0, rv); chk("R1 reset cmd word", rv, 32'h0);
    rd(2'd1, rv); chk("R7 reset status", rv, 32'h0);
    rd(2'd2, rv); chk("R8 reset enables", rv, 32'h0);
    chk("R2 reset outputs", {28'h0, filled_o, pass_o}, 32'h0);
    chk("R5 reset suspend/irq/route", {29'h0, suspend_o, irq_o, route_o}, 32'h0);

    // handshake vector table
    for (int k = 0; k < NV; k++) begin
      reg_we_i     = |VEC[k][11:10];
      reg_addr_i   = 2'd0;
      reg_wdata_i  = {29'h0, VEC[k][11:10], 1'b0};
      list_start_i = VEC[k][9:8];
      td_found_i   = VEC[k][7:6];
      list_done_i  = VEC[k][5:4];
      @(negedge clk_i);
      reg_we_i = 1'b0; reg_wdata_i = '0;
      list_start_i = '0; td_found_i = '0; list_done_i = '0;
      chk($sformatf("R2 R3 R4 vector %0d filled", k), {30'h0, filled_o}, {30'h0, VEC[k][3:2]});
      chk($sformatf("R2 R3 R4 vector %0d pass", k), {30'h0, pass_o}, {30'h0, VEC[k][1:0]});
    end

    // writes of 0 and readback
    wr(2'd0, 32'h0);
    rd(2'd0, rv); chk("R1 zero write ignored", rv, 32'h4);
    wr(2'd0, 32'h2);
    rd(2'd0, rv); chk("R1 set control flag", rv, 32'h6);

    // interrupt status
    wr(2'd2, 32'h8000_0008);
    event_i = 7'h08; @(negedge clk_i); event_i = '0;
    rd(2'd1, rv); chk("R7 event latched", rv, 32'h8);
    chk("R8 irq enabled event", {31'h0, irq_o}, 32'h1);
    wr(2'd1, 32'h4);
    rd(2'd1, rv); chk("R7 write cannot set/other bit kept", rv, 32'h8);
    wr(2'd1, 32'h8);
    rd(2'd1, rv); chk("R7 write 1 clears", rv, 32'h0);
    chk("R8 irq drops after clear", {31'h0, irq_o}, 32'h0);
    event_i = 7'h08; reg_we_i = 1'b1; reg_addr_i = 2'd1; reg_wdata_i = 32'h8;
    @(negedge clk_i);
    event_i = '0; reg_we_i = 1'b0; reg_wdata_i = '0;
    rd(2'd1, rv); chk("R7 event beats clear", rv, 32'h8);
    wr(2'd1, 32'h8);
    event_i = 7'h20; @(negedge clk_i); event_i = '0;
    rd(2'd1, rv); chk("R7 second event", rv, 32'h20);
    chk("R8 irq masked by enable", {31'h0, irq_o}, 32'h0);
    wr(2'd2, 32'h0000_0020);
    chk("R8 irq masked by master", {31'h0, irq_o}, 32'h0);
    wr(2'd2, 32'hC000_0020);
    chk("R8 irq with master", {31'h0, irq_o}, 32'h1);
    chk("R6 route set", {31'h0, route_o}, 32'h1);

    // soft reset
    wr(2'd0, 32'h1);                                     // edge E0
    chk("R5 suspend raised", {31'h0, suspend_o}, 32'h1);
    rd(2'd0, rv); chk("R5 busy bit, R6 flags cleared", rv, 32'h1);
    rd(2'd2, rv); chk("R6 enables cleared, route kept", rv, 32'h4000_0000);
    rd(2'd1, rv); chk("R6 status cleared", rv, 32'h0);
    chk("R6 irq cleared", {30'h0, irq_o, route_o}, 32'h1);
    wr(2'd0, 32'h6);                                     // E1
    chk("R6 software set during suspend", {30'h0, filled_o}, 32'h3);
    pulse_start(2'b11);                                  // E2
    chk("R6 start ignored: filled", {30'h0, filled_o}, 32'h3);
    chk("R6 start ignored: pass", {30'h0, pass_o}, 32'h0);
    wr(2'd0, 32'h1);                                     // E3
    repeat (RST - 4) @(negedge clk_i);
    rd(2'd0, rv); chk("R5 still busy at last cycle", rv, 32'h7);
    chk("R5 suspend at last cycle", {31'h0, suspend_o}, 32'h1);
    @(negedge clk_i);
    rd(2'd0, rv); chk("R5 busy self-cleared", rv, 32'h6);
    chk("R5 suspend released", {31'h0, suspend_o}, 32'h0);

    pulse_start(2'b01);
    chk("R2 start after reset", {28'h0, filled_o, pass_o}, 32'h9);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule